// File: doc/BRIEF.md
# Multi-Channel Timer Bank

A bank of independent up-counting timers sits behind a plain word-addressed register bus with single-cycle writes and combinational reads. Each timer has four registers: control, clock configuration, counter and compare. The control register selects one of three operating behaviours. One-shot raises an event once and stops. Repeat raises an event and restarts from zero. Free-running counts forever and wraps, and never raises an event.

Events set per-timer pending flags. A shared mask register gates the pending flags onto one interrupt line, and a write-one-to-clear register drops them. A single tick-enable input stands in for the clock source. A per-timer divider setting can pass only every second tick.

Top module: `timer_bank`

## Requirements
- R1: After reset every register reads 0 and `irqOut` is low.
- R2: Timer n (1..NUM_TIMERS) has control at 0x10·n, clock config at 0x04+0x10·n, counter at 0x08+0x10·n and compare at 0x0C+0x10·n. The interrupt mask is at 0x00 and the pending/acknowledge register at 0x08, with timer n at bit n−1 of both. Reads are combinational. Any other address reads 0 and ignores writes.
- R3: Control bit 0 is enable and bits [5:4] are the mode (0 one-shot, 1 repeat, 3 free-running, 2 acts as free-running). Both read back. Bit 1 is a clear command that reads as 0 and zeroes the counter and the divider phase on the edge that takes the write. A control write without bit 1 leaves the counter alone.
- R4: The counter advances by one on each clock edge where its timer is enabled and a tick passes. A free-running counter wraps at 2^CNT_W. A write to the counter address is ignored. A cycle carrying a control write for a timer gives that timer no tick.
- R5: Clock config bits [3:0] are the divider select and bit 4 is the source select; both read back. A divider select of 1 passes every second raw tick, the first passed one being the second tick after a clear. Any other value passes every tick.
- R6: In repeat mode, a passed tick that finds the counter equal to the compare value sets the pending flag and zeroes the counter, so an event comes every compare+1 ticks.
- R7: In one-shot mode the same condition sets the pending flag and clears the enable bit. The counter then holds the compare value.
- R8: Free-running mode and mode 2 never set a pending flag.
- R9: Writing the acknowledge register clears the pending bits written as 1 and leaves the others; 0x3F clears all six.
- R10: If a timer's event and an acknowledge of its bit fall in the same cycle, the flag stays set.
- R11: `irqOut` is high exactly when some timer has both its pending flag and its mask bit set.
- R12: The mask register reads back as written and has no effect on whether pending flags get set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count tick for all timers |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for `busAddr` (combinational) |
| irqOut | output | 1 | Combined masked interrupt |

## Verification
The hardest situation to bring about from the ports is an event landing in the same cycle as an acknowledge of the same bit. The bench sets every timer to repeat mode with compare 0, so each passed tick is an event. It then raises the tick input during the very cycle that carries the acknowledge write. It also disables one timer first, so the same write shows both outcomes at once: that timer's bit is cleared while the others stay pending. The benches sweep all 64 acknowledge masks and all 64 mask values, and run compare values and tick counts across one-shot, repeat, free-running and divided counting. A narrow 8-bit counter lets the wrap be reached in a few hundred cycles.

// File: rtl/timer_bank_pkg.sv
`timescale 1ns/1ps
package timer_bank_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_REPEAT  = 2'd1,
    MODE_SPARE   = 2'd2,
    MODE_FREERUN = 2'd3
  } runMode_e;

  // write strobes from the decoder to one channel
  typedef struct packed {
    logic ctrlWr;
    logic clkWr;
    logic cmpWr;
  } chanStrobe_t;

  // configuration view of one channel for readback
  typedef struct packed {
    logic     enable;
    runMode_e mode;
    logic     clkSrc;
    logic [3:0] divSel;
  } chanCfg_t;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CLK_SRC_BIT   = 4;
  localparam int CLK_DIV_W     = 4;

  localparam logic [1:0] SLOT_CTRL = 2'd0;
  localparam logic [1:0] SLOT_CLK  = 2'd1;
  localparam logic [1:0] SLOT_CNT  = 2'd2;
  localparam logic [1:0] SLOT_CMP  = 2'd3;

  localparam logic [CLK_DIV_W-1:0] DIV_BY_TWO = 4'd1;

endpackage

// File: rtl/timer_bank_ctrl.sv
`timescale 1ns/1ps
module timer_bank_ctrl
  import timer_bank_pkg::*;
#(
  parameter int NUM_TIMERS = 6,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busWrite,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [NUM_TIMERS-1:0]             maskData,
  output logic [DATA_W-1:0]                 busRdata,
  output chanStrobe_t [NUM_TIMERS-1:0]      strobe,
  input  chanCfg_t [NUM_TIMERS-1:0]         cfg,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  countVal,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cmpVal,
  input  logic [NUM_TIMERS-1:0]             matchVec,
  output logic [NUM_TIMERS-1:0]             pendQ,
  output logic [NUM_TIMERS-1:0]             ienQ,
  output logic                              irqOut
);

  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] regIdx;
  logic [1:0]       slot;
  logic             globalSel;
  logic             ienWr;
  logic             ackWr;
  logic [NUM_TIMERS-1:0] ackMask;
  logic [1:0]       unusedAddrLsb;

  assign regIdx        = busAddr[ADDR_W-1:4];
  assign slot          = busAddr[3:2];
  assign unusedAddrLsb = busAddr[1:0];
  assign globalSel     = (regIdx == '0);
  assign ienWr         = busWrite & globalSel & (slot == SLOT_CTRL);
  assign ackWr         = busWrite & globalSel & (slot == SLOT_CNT);
  assign ackMask       = ackWr ? maskData : '0;

  always_comb begin
    for (int i = 0; i < NUM_TIMERS; i++) begin
      logic chanHit;
      chanHit = busWrite & (regIdx == IDX_W'(i + 1));
      strobe[i].ctrlWr = chanHit & (slot == SLOT_CTRL);
      strobe[i].clkWr  = chanHit & (slot == SLOT_CLK);
      strobe[i].cmpWr  = chanHit & (slot == SLOT_CMP);
    end
  end

  // pending flags: an event in the same cycle outranks an acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      ienQ  <= '0;
    end else begin
      pendQ <= (pendQ & ~ackMask) | matchVec;
      if (ienWr) ienQ <= maskData;
    end
  end

  assign irqOut = |(pendQ & ienQ);

  always_comb begin
    busRdata = '0;
    if (globalSel) begin
      case (slot)
        SLOT_CTRL: busRdata[NUM_TIMERS-1:0] = ienQ;
        SLOT_CNT:  busRdata[NUM_TIMERS-1:0] = pendQ;
        default:   busRdata = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_TIMERS; i++) begin
        if (regIdx == IDX_W'(i + 1)) begin
          case (slot)
            SLOT_CTRL: begin
              busRdata[CTRL_EN_BIT]          = cfg[i].enable;
              busRdata[CTRL_MODE_LSB +: 2]   = cfg[i].mode;
            end
            SLOT_CLK: begin
              busRdata[CLK_DIV_W-1:0]        = cfg[i].divSel;
              busRdata[CLK_SRC_BIT]          = cfg[i].clkSrc;
            end
            SLOT_CNT: busRdata[CNT_W-1:0]    = countVal[i];
            default:  busRdata[CNT_W-1:0]    = cmpVal[i];
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/timer_bank_datapath.sv
`timescale 1ns/1ps
module timer_bank_datapath
  import timer_bank_pkg::*;
#(
  parameter int NUM_TIMERS = 6,
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              tickEn,
  input  chanStrobe_t [NUM_TIMERS-1:0]      strobe,
  input  logic [DATA_W-1:0]                 busWdata,
  output chanCfg_t [NUM_TIMERS-1:0]         cfg,
  output logic [NUM_TIMERS-1:0][CNT_W-1:0]  countVal,
  output logic [NUM_TIMERS-1:0][CNT_W-1:0]  cmpVal,
  output logic [NUM_TIMERS-1:0]             matchVec,
  output logic [NUM_TIMERS-1:0]             enVec
);

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chan
    logic                 enQ;
    runMode_e             modeQ;
    logic                 srcQ;
    logic [CLK_DIV_W-1:0] divQ;
    logic [CNT_W-1:0]     cntQ;
    logic [CNT_W-1:0]     cmpQ;
    logic                 phaseQ;
    logic                 tickPass;
    logic                 advance;
    logic                 usesCompare;
    logic                 hit;

    always_comb begin
      tickPass    = tickEn & ((divQ == DIV_BY_TWO) ? phaseQ : 1'b1);
      advance     = enQ & tickPass & ~strobe[g].ctrlWr;
      usesCompare = (modeQ == MODE_ONESHOT) || (modeQ == MODE_REPEAT);
      hit         = advance & usesCompare & (cntQ == cmpQ);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ    <= 1'b0;
        modeQ  <= MODE_ONESHOT;
        srcQ   <= 1'b0;
        divQ   <= '0;
        cntQ   <= '0;
        cmpQ   <= '0;
        phaseQ <= 1'b0;
      end else begin
        if (strobe[g].clkWr) begin
          srcQ <= busWdata[CLK_SRC_BIT];
          divQ <= busWdata[CLK_DIV_W-1:0];
        end
        if (strobe[g].cmpWr) cmpQ <= busWdata[CNT_W-1:0];
        if (strobe[g].ctrlWr) begin
          enQ   <= busWdata[CTRL_EN_BIT];
          modeQ <= runMode_e'(busWdata[CTRL_MODE_LSB +: 2]);
          if (busWdata[CTRL_CLR_BIT]) begin
            cntQ   <= '0;
            phaseQ <= 1'b0;
          end
        end else if (enQ && tickEn) begin
          phaseQ <= ~phaseQ;
          if (hit) begin
            if (modeQ == MODE_REPEAT) cntQ <= '0;
            else                      enQ  <= 1'b0;
          end else if (advance) begin
            cntQ <= cntQ + 1'b1;
          end
        end
      end
    end

    assign cfg[g]      = '{enable: enQ, mode: modeQ, clkSrc: srcQ, divSel: divQ};
    assign countVal[g] = cntQ;
    assign cmpVal[g]   = cmpQ;
    assign matchVec[g] = hit;
    assign enVec[g]    = enQ;
  end

endmodule

// File: rtl/timer_bank.sv
`timescale 1ns/1ps
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NUM_TIMERS = 6,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);

  chanStrobe_t [NUM_TIMERS-1:0]     strobe;
  chanCfg_t [NUM_TIMERS-1:0]        cfg;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] countVal;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] cmpVal;
  logic [NUM_TIMERS-1:0]            matchVec;
  logic [NUM_TIMERS-1:0]            enVec;
  logic [NUM_TIMERS-1:0]            pendQ;
  logic [NUM_TIMERS-1:0]            ienQ;

  timer_bank_ctrl #(
    .NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .maskData(busWdata[NUM_TIMERS-1:0]), .busRdata(busRdata),
    .strobe(strobe), .cfg(cfg), .countVal(countVal), .cmpVal(cmpVal),
    .matchVec(matchVec), .pendQ(pendQ), .ienQ(ienQ), .irqOut(irqOut)
  );

  timer_bank_datapath #(
    .NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .busWdata(busWdata), .cfg(cfg), .countVal(countVal), .cmpVal(cmpVal),
    .matchVec(matchVec), .enVec(enVec)
  );

endmodule

// File: rtl/timer_bank_checker.sv
`timescale 1ns/1ps
module timer_bank_checker #(
  parameter int NUM_TIMERS = 6,
  parameter int ADDR_W     = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWrite,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [NUM_TIMERS-1:0] ackData,
  input logic                  irqOut,
  input logic [NUM_TIMERS-1:0] pendQ,
  input logic [NUM_TIMERS-1:0] ienQ,
  input logic [NUM_TIMERS-1:0] matchVec,
  input logic [NUM_TIMERS-1:0] enVec
);

  localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(8);

  // R10: an event always leaves its flag set on the next cycle
  assert_event_sets_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|matchVec) |=> ((pendQ & $past(matchVec)) == $past(matchVec)));

  // R6: a flag can only appear as the result of an event
  assert_flag_needs_event_R6: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((pendQ & ~$past(pendQ) & ~$past(matchVec)) == '0));

  // R9: acknowledged bits without a concurrent event are cleared
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ACK_ADDR) |=>
      ((pendQ & $past(ackData) & ~$past(matchVec)) == '0));

  // R11: the interrupt line needs at least one mask bit
  assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|ienQ));

  // R4: only enabled timers produce events
  assert_event_needs_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|matchVec) |-> ((matchVec & ~enVec) == '0));

endmodule

bind timer_bank timer_bank_checker #(.NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W)) i_checker (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
  .ackData(busWdata[NUM_TIMERS-1:0]), .irqOut(irqOut), .pendQ(pendQ),
  .ienQ(ienQ), .matchVec(matchVec), .enVec(enVec)
);

// File: tb/test_timer_bank.sv
`timescale 1ns/1ps
module test_timer_bank;

  localparam int NT = 6;
  localparam int CW = 8;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  timer_bank #(.NUM_TIMERS(NT), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) i_timer_bank (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic logic [AW-1:0] regAddr(int n, int slot);
    return AW'(16 * n + 4 * slot);
  endfunction

  task automatic checkEq(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic chkRd(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    checkEq(tag, busRdata, exp);
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  // mode code, clear and enable: ctrl = mode<<4 | 2 | 1
  task automatic startTimer(int n, int mode, int cmp, int div);
    wr(regAddr(n, 1), DW'(div));
    wr(regAddr(n, 3), DW'(cmp));
    wr(regAddr(n, 0), DW'((mode << 4) | 3));
  endtask

  task automatic stopAll();
    for (int n = 1; n <= NT; n++) wr(regAddr(n, 0), 32'h2);
    wr(8'h08, 32'h3F);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    for (int a = 0; a < 16 * (NT + 1); a += 4) chkRd(AW'(a), 32'h0, "R1 reset read");
    checkEq("R1 irq after reset", DW'(irqOut), 32'h0);

    // R2 R3 R5: map and readback
    for (int n = 1; n <= NT; n++) begin
      wr(regAddr(n, 3), 32'hFFFF_FF00 | DW'((n * 37 + 5) & 8'hFF));
      wr(regAddr(n, 1), 32'hFFFF_FFE0 | DW'(((n & 1) << 4) | n));
      wr(regAddr(n, 0), DW'(((n % 4) << 4) | 2));
      wr(regAddr(n, 2), 32'hAB);
    end
    for (int n = 1; n <= NT; n++) begin
      chkRd(regAddr(n, 3), DW'((n * 37 + 5) & 8'hFF), "R2 compare readback");
      chkRd(regAddr(n, 1), DW'(((n & 1) << 4) | n), "R5 clock config readback");
      chkRd(regAddr(n, 0), DW'((n % 4) << 4), "R3 control readback, clear reads 0");
      chkRd(regAddr(n, 2), 32'h0, "R4 counter write ignored");
    end
    wr(8'h00, 32'h2A);
    chkRd(8'h00, 32'h2A, "R12 mask readback");
    wr(8'h00, 32'h0);
    wr(AW'(16 * (NT + 1)), 32'hFFFF_FFFF);
    chkRd(AW'(16 * (NT + 1)), 32'h0, "R2 unmapped timer slot");
    chkRd(8'h04, 32'h0, "R2 unmapped global 0x04");
    chkRd(8'h0C, 32'h0, "R2 unmapped global 0x0C");
    stopAll();

    // R4: free-running counts per timer, others stay idle
    for (int n = 1; n <= NT; n++) begin
      startTimer(n, 3, 0, 0);
      ticks(3 * n + 1);
      chkRd(regAddr(n, 2), DW'(3 * n + 1), "R4 free count");
      chkRd(regAddr((n % NT) + 1, 2), 32'h0, "R4 disabled timer idle");
      repeat (5) @(negedge clk);
      chkRd(regAddr(n, 2), DW'(3 * n + 1), "R4 no tick no advance");
      wr(regAddr(n, 0), 32'h2);
    end

    // R4 R8: wrap past compare, no flag
    startTimer(1, 3, 5, 0);
    ticks(300);
    chkRd(regAddr(1, 2), DW'(300 % 256), "R4 wrap");
    chkRd(8'h08, 32'h0, "R8 free-run no pending");
    // R8: mode 2 behaves as free-running
    startTimer(2, 2, 2, 0);
    ticks(5);
    chkRd(regAddr(2, 2), 32'd5, "R8 mode 2 count");
    chkRd(8'h08, 32'h0, "R8 mode 2 no pending");
    stopAll();

    // R4: control write cycle takes no tick
    startTimer(5, 3, 0, 0);
    ticks(3);
    @(negedge clk);
    busWrite = 1'b1; busAddr = regAddr(5, 0); busWdata = 32'h31; tickEn = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; tickEn = 1'b0;
    chkRd(regAddr(5, 2), 32'd3, "R4 control write blocks tick");
    stopAll();

    // R5: divider sweep
    for (int k = 1; k <= 7; k++) begin
      startTimer(3, 3, 0, 1);
      ticks(k);
      chkRd(regAddr(3, 2), DW'(k / 2), "R5 divide by two");
      startTimer(4, 3, 0, 2);
      ticks(k);
      chkRd(regAddr(4, 2), DW'(k), "R5 other divider value passes all");
      stopAll();
    end

    // R6: repeat sweep
    for (int c = 0; c <= 4; c++) begin
      int n;
      n = (c % NT) + 1;
      startTimer(n, 1, c, 0);
      wr(8'h08, 32'h3F);
      if (c > 0) begin
        ticks(c);
        chkRd(regAddr(n, 2), DW'(c), "R6 before match count");
        chkRd(8'h08, 32'h0, "R6 before match pending");
      end
      ticks(1);
      chkRd(regAddr(n, 2), 32'h0, "R6 wrap to zero on match");
      chkRd(8'h08, DW'(1 << (n - 1)), "R6 pending bit n-1");
      ticks(2 * c + 1);
      chkRd(regAddr(n, 2), DW'((2 * c + 1) % (c + 1)), "R6 period compare+1");
      chkRd(regAddr(n, 0), 32'h11, "R6 stays enabled");
      stopAll();
    end

    // R7: one-shot
    startTimer(2, 0, 3, 0);
    ticks(3);
    chkRd(8'h08, 32'h0, "R7 no pending before match");
    ticks(1);
    chkRd(8'h08, 32'h2, "R7 pending after match");
    chkRd(regAddr(2, 0), 32'h0, "R7 enable cleared");
    ticks(5);
    chkRd(regAddr(2, 2), 32'd3, "R7 counter holds");
    stopAll();

    // R3: clear command
    startTimer(4, 3, 0, 0);
    ticks(9);
    wr(regAddr(4, 0), 32'h33);
    chkRd(regAddr(4, 2), 32'h0, "R3 clear zeroes counter");
    chkRd(regAddr(4, 0), 32'h31, "R3 clear reads 0");
    ticks(4);
    wr(regAddr(4, 0), 32'h30);
    chkRd(regAddr(4, 2), 32'd4, "R3 write without clear keeps count");
    ticks(3);
    chkRd(regAddr(4, 2), 32'd4, "R4 disabled holds");
    stopAll();

    // R9 R12: all timers repeat with compare 0, mask 0
    for (int n = 1; n <= NT; n++) startTimer(n, 1, 0, 0);
    for (int m = 0; m < 64; m++) begin
      ticks(1);
      if (m == 0) chkRd(8'h08, 32'h3F, "R12 flags set with mask 0");
      wr(8'h08, DW'(m));
      chkRd(8'h08, DW'(6'h3F & ~m), "R9 ack clears written bits");
    end
    checkEq("R12 irq low with mask 0", DW'(irqOut), 32'h0);

    // R10: event and ack in one cycle
    ticks(1);
    @(negedge clk);
    busWrite = 1'b1; busAddr = 8'h08; busWdata = 32'h3F; tickEn = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; tickEn = 1'b0;
    chkRd(8'h08, 32'h3F, "R10 event wins over ack");
    wr(regAddr(3, 0), 32'h10);
    @(negedge clk);
    busWrite = 1'b1; busAddr = 8'h08; busWdata = 32'h3F; tickEn = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; tickEn = 1'b0;
    chkRd(8'h08, 32'h3B, "R10 disabled timer cleared, others kept");

    // R11: mask sweep with pending 0x2A
    ticks(1);
    wr(8'h08, 32'h15);
    chkRd(8'h08, 32'h2A, "R9 partial ack");
    for (int m = 0; m < 64; m++) begin
      wr(8'h00, DW'(m));
      @(negedge clk);
      checkEq("R11 irq = OR(pending & mask)", DW'(irqOut), DW'((m & 6'h2A) != 0));
    end
    chkRd(8'h00, 32'h3F, "R12 mask readback after sweep");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule